// File: doc/BRIEF.md
# Addressed Three-Wire Register Port

This block is a serial slave that lets an external controller write two 24-bit control words and read back status over three lines: a bit clock, a frame strobe and one bidirectional data line. Each frame carries 32 bits, most significant bit first. The first 8 bits are an address and the last 24 are data. The frame strobe rises to open a frame and falls to close it. The bit clock idles high. The controller changes the data line after each falling clock edge, and bits are taken on each rising edge.

All three lines are resampled by the block's own clock through a synchronizer before any logic sees them. Writes take effect only when the frame closes. A read is recognised when the clock falls for the ninth time, which is right after the address byte. At that edge the block freezes a 24-bit readback word, takes over the data line and presents that word on the following falling edges. One read address returns either live counter status or the first control word, selected by a bit of that control word. The other read address merges the second control word with the state of five input pins.

Top module: `tw_regport`

## Requirements
- R1: After reset both control words (`ctrl_a`, `ctrl_b`) are zero, `ser_doe` is 0 and `ser_dout` is 0.
- R2: A 32-bit frame addressed 0xD0 loads its 24 data bits into `ctrl_a` when the frame strobe falls, and not earlier.
- R3: A 32-bit frame addressed 0xD2 loads its 24 data bits into `ctrl_b` when the frame strobe falls.
- R4: A frame with any other address, or with fewer or more than 32 rising clock edges, leaves both control words unchanged.
- R5: A read of 0xD1 while `ctrl_a[0]` is 0 returns a word built as follows: `cnt_value` in bits 23:8, `cnt_over` in bit 7, `cnt_busy` in bit 6, `pll_unlock` in bit 5, `pll_valid` in bit 4, and zeros in bits 3:0.
- R6: A read of 0xD1 while `ctrl_a[0]` is 1 returns `ctrl_a`.
- R7: A read of 0xD3 returns `ctrl_b[23:5]` in bits 23:5 and `io_pins_in` in bits 4:0.
- R8: The readback word is sampled at the ninth falling clock edge. Input changes after that edge do not alter the bits still to be shifted out.
- R9: In a read frame, `ser_doe` rises at the ninth falling clock edge and drops when the frame strobe falls. It stays 0 throughout write frames. Readback bits appear on `ser_dout` MSB first, one per falling clock edge.
- R10: A rising clock edge that reaches the block in the same cycle as the falling frame strobe is not counted, so a complete frame still commits.
- R11: A rising frame strobe restarts the bit count, so a full frame that follows an aborted one is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, idles high |
| ser_frame | input | 1 | Frame strobe, high during a frame |
| ser_din | input | 1 | Serial data from the controller |
| ser_dout | output | 1 | Readback data toward the controller |
| ser_doe | output | 1 | Drive enable for the shared data line |
| cnt_value | input | 16 | Counter result for status readback |
| cnt_over | input | 1 | Counter overflow flag |
| cnt_busy | input | 1 | Counter measurement in progress |
| pll_unlock | input | 1 | Loop unlock flag |
| pll_valid | input | 1 | Unlock flag is valid |
| io_pins_in | input | 5 | Input levels of the general-purpose pins |
| ctrl_a | output | 24 | First control word |
| ctrl_b | output | 24 | Second control word |

## Verification
The closing strobe edge and a rising bit-clock edge can be resampled in the same cycle. If that rising edge were counted, the bit count would reach 33 and a valid frame would be thrown away. The bench drives a complete write frame, lowers the bit clock once more, and then raises it in the same instant as the frame strobe falls. It then expects the written word to be present on `ctrl_a`. A second case covers the pin snapshot: the input pins change partway through a read, and the bench expects the values that were present at the ninth falling edge.

// File: rtl/tw_regport_pkg.sv
package tw_regport_pkg;

  // Default address map of the port
  localparam logic [7:0] WR_A_ADDR_DEF = 8'hD0;
  localparam logic [7:0] RD_A_ADDR_DEF = 8'hD1;
  localparam logic [7:0] WR_B_ADDR_DEF = 8'hD2;
  localparam logic [7:0] RD_B_ADDR_DEF = 8'hD3;

  // Bit of ctrl_a that swaps the 0xD1 readback source
  localparam int OC_BIT_DEF = 0;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_CTRL_A = 2'd2,
    RD_CTRL_B = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_async[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign d_sync[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx #(
  parameter int FRAME_W = 32,
  parameter int BCNT_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_lvl,
  input  logic               frame_rise,
  input  logic               sclk_rise,
  input  logic               din_lvl,
  output logic [FRAME_W-1:0] shift_q,
  output logic [BCNT_W-1:0]  bit_cnt_q
);

  logic [FRAME_W-1:0] shift_d;
  logic [BCNT_W-1:0]  bit_cnt_d;
  logic               shift_en;

  // A rising edge counts only while the synchronized strobe is still high
  assign shift_en = frame_lvl & sclk_rise & ~frame_rise;

  always_comb begin
    shift_d   = shift_q;
    bit_cnt_d = bit_cnt_q;
    if (frame_rise) begin
      shift_d   = '0;
      bit_cnt_d = '0;
    end else if (shift_en) begin
      shift_d = {shift_q[FRAME_W-2:0], din_lvl};
      if (bit_cnt_q != '1) bit_cnt_d = bit_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      bit_cnt_q <= '0;
    end else begin
      shift_q   <= shift_d;
      bit_cnt_q <= bit_cnt_d;
    end
  end

endmodule

// File: rtl/tw_readback.sv
module tw_readback
  import tw_regport_pkg::*;
#(
  parameter int               WORD_W    = 24,
  parameter int               ADDR_W    = 8,
  parameter int               CNT_W     = 16,
  parameter int               IO_W      = 5,
  parameter int               BCNT_W    = 7,
  parameter int               OC_BIT    = 0,
  parameter logic [ADDR_W-1:0] RD_A_ADDR = ADDR_W'(RD_A_ADDR_DEF),
  parameter logic [ADDR_W-1:0] RD_B_ADDR = ADDR_W'(RD_B_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_lvl,
  input  logic              frame_rise,
  input  logic              frame_fall,
  input  logic              sclk_fall,
  input  logic [BCNT_W-1:0] bit_cnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] ctrl_a,
  input  logic [WORD_W-1:0] ctrl_b,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_over,
  input  logic              cnt_busy,
  input  logic              pll_unlock,
  input  logic              pll_valid,
  input  logic [IO_W-1:0]   io_lvl,
  output logic              cap,
  output logic              dout,
  output logic              doe
);

  localparam int PAD_W = WORD_W - CNT_W - 4;

  rd_sel_e           sel;
  logic [WORD_W-1:0] status_word;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] out_q, out_d;
  logic              oe_q, oe_d;
  logic              addr_done;

  assign status_word = {cnt_value, cnt_over, cnt_busy, pll_unlock, pll_valid, {PAD_W{1'b0}}};

  always_comb begin
    if (addr == RD_A_ADDR)      sel = ctrl_a[OC_BIT] ? RD_CTRL_A : RD_STATUS;
    else if (addr == RD_B_ADDR) sel = RD_CTRL_B;
    else                        sel = RD_NONE;
  end

  always_comb begin
    case (sel)
      RD_STATUS: word = status_word;
      RD_CTRL_A: word = ctrl_a;
      RD_CTRL_B: word = {ctrl_b[WORD_W-1:IO_W], io_lvl};
      default:   word = '0;
    endcase
  end

  // Ninth falling edge: the address byte is complete
  assign addr_done = frame_lvl & sclk_fall & (bit_cnt == BCNT_W'(ADDR_W));
  assign cap       = addr_done & (sel != RD_NONE);

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    if (frame_rise || frame_fall) begin
      oe_d = 1'b0;
    end else if (cap) begin
      out_d = word;
      oe_d  = 1'b1;
    end else if (oe_q && sclk_fall) begin
      out_d = {out_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign dout = oe_q & out_q[WORD_W-1];
  assign doe  = oe_q;

endmodule

// File: rtl/tw_regport.sv
module tw_regport
  import tw_regport_pkg::*;
#(
  parameter int                WORD_W     = 24,
  parameter int                ADDR_W     = 8,
  parameter int                CNT_W      = 16,
  parameter int                IO_W       = 5,
  parameter int                SYNC_STG   = 2,
  parameter int                OC_BIT     = OC_BIT_DEF,
  parameter logic [ADDR_W-1:0] WR_A_ADDR  = ADDR_W'(WR_A_ADDR_DEF),
  parameter logic [ADDR_W-1:0] RD_A_ADDR  = ADDR_W'(RD_A_ADDR_DEF),
  parameter logic [ADDR_W-1:0] WR_B_ADDR  = ADDR_W'(WR_B_ADDR_DEF),
  parameter logic [ADDR_W-1:0] RD_B_ADDR  = ADDR_W'(RD_B_ADDR_DEF),
  parameter logic [WORD_W-1:0] CTRL_A_RST = '0,
  parameter logic [WORD_W-1:0] CTRL_B_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_frame,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_doe,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_over,
  input  logic              cnt_busy,
  input  logic              pll_unlock,
  input  logic              pll_valid,
  input  logic [IO_W-1:0]   io_pins_in,
  output logic [WORD_W-1:0] ctrl_a,
  output logic [WORD_W-1:0] ctrl_b
);

  localparam int FRAME_W = ADDR_W + WORD_W;
  localparam int BCNT_W  = $clog2(FRAME_W) + 2;
  localparam int SYNC_N  = IO_W + 3;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Synchronize the serial lines and the pin inputs
  logic [SYNC_N-1:0] sync_out;
  logic              sclk_lvl, frame_lvl, din_lvl;
  logic [IO_W-1:0]   io_lvl;

  tw_sync #(.N(SYNC_N), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({io_pins_in, ser_din, ser_frame, ser_clk}),
    .d_sync  (sync_out)
  );

  assign sclk_lvl  = sync_out[0];
  assign frame_lvl = sync_out[1];
  assign din_lvl   = sync_out[2];
  assign io_lvl    = sync_out[SYNC_N-1:3];

  // Edge detection on the synchronized bit clock and strobe
  logic sclk_prev_q, frame_prev_q;
  logic sclk_rise, sclk_fall, frame_rise, frame_fall;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_prev_q  <= 1'b0;
      frame_prev_q <= 1'b0;
    end else begin
      sclk_prev_q  <= sclk_lvl;
      frame_prev_q <= frame_lvl;
    end
  end

  assign sclk_rise  =  sclk_lvl  & ~sclk_prev_q;
  assign sclk_fall  = ~sclk_lvl  &  sclk_prev_q;
  assign frame_rise =  frame_lvl & ~frame_prev_q;
  assign frame_fall = ~frame_lvl &  frame_prev_q;

  // Frame reception
  logic [FRAME_W-1:0] shift_q;
  logic [BCNT_W-1:0]  bit_cnt;

  tw_frame_rx #(.FRAME_W(FRAME_W), .BCNT_W(BCNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_lvl  (frame_lvl),
    .frame_rise (frame_rise),
    .sclk_rise  (sclk_rise),
    .din_lvl    (din_lvl),
    .shift_q    (shift_q),
    .bit_cnt_q  (bit_cnt)
  );

  // Control words, committed when a complete frame closes
  logic [WORD_W-1:0] ctrl_a_q, ctrl_a_d, ctrl_b_q, ctrl_b_d;
  logic [ADDR_W-1:0] frm_addr;
  logic [WORD_W-1:0] frm_data;
  logic              commit;

  assign frm_addr = shift_q[FRAME_W-1 -: ADDR_W];
  assign frm_data = shift_q[WORD_W-1:0];
  assign commit   = frame_fall & (bit_cnt == BCNT_W'(FRAME_W));

  always_comb begin
    ctrl_a_d = ctrl_a_q;
    ctrl_b_d = ctrl_b_q;
    if (commit && frm_addr == WR_A_ADDR) ctrl_a_d = frm_data;
    if (commit && frm_addr == WR_B_ADDR) ctrl_b_d = frm_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_a_q <= CTRL_A_RST;
      ctrl_b_q <= CTRL_B_RST;
    end else begin
      ctrl_a_q <= ctrl_a_d;
      ctrl_b_q <= ctrl_b_d;
    end
  end

  assign ctrl_a = ctrl_a_q;
  assign ctrl_b = ctrl_b_q;

  // Readback
  logic cap;

  tw_readback #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IO_W(IO_W),
    .BCNT_W(BCNT_W), .OC_BIT(OC_BIT), .RD_A_ADDR(RD_A_ADDR), .RD_B_ADDR(RD_B_ADDR)
  ) u_rb (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_lvl  (frame_lvl),
    .frame_rise (frame_rise),
    .frame_fall (frame_fall),
    .sclk_fall  (sclk_fall),
    .bit_cnt    (bit_cnt),
    .addr       (shift_q[ADDR_W-1:0]),
    .ctrl_a     (ctrl_a_q),
    .ctrl_b     (ctrl_b_q),
    .cnt_value  (cnt_value),
    .cnt_over   (cnt_over),
    .cnt_busy   (cnt_busy),
    .pll_unlock (pll_unlock),
    .pll_valid  (pll_valid),
    .io_lvl     (io_lvl),
    .cap        (cap),
    .dout       (ser_dout),
    .doe        (ser_doe)
  );

endmodule

// File: rtl/tw_regport_chk.sv
module tw_regport_chk #(
  parameter int WORD_W  = 24,
  parameter int BCNT_W  = 7,
  parameter int FRAME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_fall,
  input logic              sclk_fall,
  input logic              cap,
  input logic [BCNT_W-1:0] bit_cnt,
  input logic              doe,
  input logic              dout,
  input logic [WORD_W-1:0] ctrl_a,
  input logic [WORD_W-1:0] ctrl_b
);

  // R2: ctrl_a moves only right after a complete frame closes
  a_r2_ctrl_a_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_a != $past(ctrl_a)) |-> ($past(frame_fall) && $past(bit_cnt) == BCNT_W'(FRAME_W)));

  // R3: same rule for ctrl_b
  a_r3_ctrl_b_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_b != $past(ctrl_b)) |-> ($past(frame_fall) && $past(bit_cnt) == BCNT_W'(FRAME_W)));

  // R4: a close with the wrong bit count changes neither word
  a_r4_short_long_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_fall && bit_cnt != BCNT_W'(FRAME_W)) |=> ($stable(ctrl_a) && $stable(ctrl_b)));

  // R9: drive enable rises only after a readback capture
  a_r9_oe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe) |-> $past(cap));

  // R9: drive enable is released once the frame closes
  a_r9_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_fall) |-> !doe);

  // R8: while driving, the data bit changes only after a falling bit clock
  a_r8_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (doe && $past(doe) && !$past(sclk_fall)) |-> $stable(dout));

endmodule

bind tw_regport tw_regport_chk #(.WORD_W(WORD_W), .BCNT_W(BCNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_fall (frame_fall),
  .sclk_fall  (sclk_fall),
  .cap        (cap),
  .bit_cnt    (bit_cnt),
  .doe        (ser_doe),
  .dout       (ser_dout),
  .ctrl_a     (ctrl_a),
  .ctrl_b     (ctrl_b)
);

// File: tb/tw_regport_bench.sv
`timescale 1ns/1ps
module tw_regport_bench;

  localparam int PH = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_frame, ser_din;
  logic        ser_dout, ser_doe;
  logic [15:0] cnt_value;
  logic        cnt_over, cnt_busy, pll_unlock, pll_valid;
  logic [4:0]  io_pins_in;
  logic [23:0] ctrl_a, ctrl_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [23:0] m_a = '0, m_b = '0;

  always #2.5 clk = ~clk;

  tw_regport u_tw_regport (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .cnt_value(cnt_value), .cnt_over(cnt_over),
    .cnt_busy(cnt_busy), .pll_unlock(pll_unlock), .pll_valid(pll_valid),
    .io_pins_in(io_pins_in), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] status_word();
    return {cnt_value, cnt_over, cnt_busy, pll_unlock, pll_valid, 4'b0000};
  endfunction

  function automatic logic [23:0] expect_read(input logic [7:0] a);
    if (a == 8'hD1) return m_a[0] ? m_a : status_word();
    if (a == 8'hD3) return {m_b[23:5], io_pins_in};
    return 24'h0;
  endfunction

  // One frame: nbits clock cycles, optional pin change, optional stray edge at close
  task automatic xfer(input logic [7:0] a, input logic [23:0] d, input int nbits,
                      input int chg_at, input logic [4:0] chg_val, input bit stray,
                      output logic [23:0] rd, output logic oe7, output logic oe8,
                      output logic [23:0] pre_a);
    logic [31:0] fr;
    fr  = {a, d};
    rd  = '0;
    oe7 = 1'b0;
    oe8 = 1'b0;
    ser_frame = 1'b1;
    idle(PH);
    for (int i = 0; i < nbits; i++) begin
      ser_clk = 1'b0;
      if (i < 32) ser_din = fr[31-i];
      else        ser_din = 1'b0;
      idle(PH);
      if (i == 7) oe7 = ser_doe;
      if (i == 8) oe8 = ser_doe;
      if (i >= 8 && i < 32) rd[31-i] = ser_dout;
      if (i == chg_at) io_pins_in = chg_val;
      ser_clk = 1'b1;
      idle(PH);
    end
    pre_a = ctrl_a;
    if (stray) begin
      ser_clk = 1'b0;
      idle(PH);
      ser_clk   = 1'b1;
      ser_frame = 1'b0;
    end else begin
      ser_frame = 1'b0;
    end
    idle(PH);
  endtask

  task automatic wr(input logic [7:0] a, input logic [23:0] d);
    logic [23:0] rd, pa;
    logic o7, o8;
    xfer(a, d, 32, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    if (a == 8'hD0) m_a = d;
    if (a == 8'hD2) m_b = d;
    chk("R9 write keeps drive off", {23'b0, o8}, 24'h0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [23:0] rd, pa, ex;
    logic o7, o8;
    ex = expect_read(a);
    xfer(a, 24'h0, 32, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    chk(req, rd, ex);
  endtask

  initial begin
    logic [23:0] rd, pa, ex, d;
    logic o7, o8;
    logic [7:0] a;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; ser_clk = 1'b1; ser_frame = 1'b0; ser_din = 1'b0;
    cnt_value = '0; cnt_over = 0; cnt_busy = 0; pll_unlock = 0; pll_valid = 0;
    io_pins_in = '0;
    idle(5);
    rst_n = 1'b1;
    idle(8);

    chk("R1 ctrl_a reset", ctrl_a, 24'h0);
    chk("R1 ctrl_b reset", ctrl_b, 24'h0);
    chk("R1 drive off", {22'b0, ser_doe, ser_dout}, 24'h0);

    // R5 and R9: status readback with OC clear
    cnt_value = 16'hA5C3; cnt_over = 1; cnt_busy = 0; pll_unlock = 1; pll_valid = 0;
    ex = expect_read(8'hD1);
    xfer(8'hD1, 24'h0, 32, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    chk("R5 status word", rd, ex);
    chk("R9 drive off before 9th fall", {23'b0, o7}, 24'h0);
    chk("R9 drive on at 9th fall", {23'b0, o8}, 24'h1);
    chk("R9 drive off after close", {23'b0, ser_doe}, 24'h0);

    // R2: write takes effect at the close only
    xfer(8'hD0, 24'h5A5A5A, 32, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    m_a = 24'h5A5A5A;
    chk("R2 no change before close", pa, 24'h0);
    chk("R2 ctrl_a loaded", ctrl_a, 24'h5A5A5A);

    // R6: OC set, 0xD1 returns ctrl_a
    wr(8'hD0, 24'h123457);
    rd_chk("R6 ctrl_a readback", 8'hD1);

    // R3 and R7
    wr(8'hD2, 24'hC0FFEE);
    chk("R3 ctrl_b loaded", ctrl_b, 24'hC0FFEE);
    io_pins_in = 5'b10110;
    idle(PH);
    rd_chk("R7 ctrl_b with pins", 8'hD3);

    // R8: pins change after the capture edge
    ex = expect_read(8'hD3);
    xfer(8'hD3, 24'h0, 32, 10, 5'b01001, 1'b0, rd, o7, o8, pa);
    chk("R8 snapshot held", rd, ex);

    // R4: unknown address, short and long frames
    wr(8'hD5, 24'hFFFFFF);
    chk("R4 unknown address a", ctrl_a, m_a);
    chk("R4 unknown address b", ctrl_b, m_b);
    xfer(8'hD0, 24'h00AAAA, 31, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    chk("R4 short frame", ctrl_a, m_a);
    xfer(8'hD2, 24'h0BBBB0, 33, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    chk("R4 long frame", ctrl_b, m_b);

    // R11: aborted frame then a full one
    xfer(8'hD2, 24'h777777, 5, -1, 5'b0, 1'b0, rd, o7, o8, pa);
    chk("R4 aborted frame", ctrl_b, m_b);
    wr(8'hD2, 24'h0BEEF1);
    chk("R11 restart decodes", ctrl_b, 24'h0BEEF1);

    // R10: stray rising edge together with the close
    xfer(8'hD0, 24'h00FACE, 32, -1, 5'b0, 1'b1, rd, o7, o8, pa);
    m_a = 24'h00FACE;
    chk("R10 stray edge ignored", ctrl_a, 24'h00FACE);

    // Random traffic
    for (int k = 0; k < 40; k++) begin
      cnt_value  = 16'($urandom);
      {cnt_over, cnt_busy, pll_unlock, pll_valid} = 4'($urandom);
      io_pins_in = 5'($urandom);
      d = 24'($urandom);
      case ($urandom % 4)
        0: a = 8'hD0;
        1: a = 8'hD2;
        2: a = 8'($urandom);
        default: a = 8'hD0;
      endcase
      if (a == 8'hD1 || a == 8'hD3) a = 8'hD4;
      wr(a, d);
      chk("R2 R3 R4 random ctrl_a", ctrl_a, m_a);
      chk("R2 R3 R4 random ctrl_b", ctrl_b, m_b);
      rd_chk(m_a[0] ? "R6 random" : "R5 random", 8'hD1);
      rd_chk("R7 random", 8'hD3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule